// File: doc/BRIEF.md
# Reloadable Event Down-Counter

This block is one channel of a 16-bit event-counting timer. Each qualifying event takes one off the counter. When an event arrives while the counter is at zero, the counter reloads from a reload register and keeps counting. The channel therefore emits one underflow for every n+1 events, where n is the value software wrote. Each underflow drives a single-cycle pulse that a neighbouring channel can count, and an interrupt request.

Events come from one of two places. The first is an asynchronous input pin, which is synchronised and then edge-detected on its falling edges, its rising edges or both. The second is the underflow pulse of the preceding channel in a ring of channels. Software drives a small register interface:

- a configuration write that sets the operating mode, the pin edge choice and the source choice;
- a run bit;
- a count write, with the live count always readable.

A count write reaches the counter as well as the reload register only until the first event after start. From then on it changes only the reload value, which the counter takes at its next reload.

Top module: `evt_down_timer`

## Requirements
- R1: Reset (rst_n low at a clock edge) leaves the count at 0, the reload value at 0, the run bit at 0 and both uflow_pulse and irq_req low.
- R2: While running with cfg_op_mode equal to 2'b01, each qualifying event lowers the count by one, and the new value appears on cnt_rdata after the clock edge that samples the event.
- R3: An event that finds the count at 0 reloads the counter from the reload value. In the cycle after that edge, uflow_pulse and irq_req are both high for exactly that one cycle. With a reload value of 0, every event underflows.
- R4: With cfg_src_chain = 0, cfg_edge selects the pin edges that count: 2'b00 falling, 2'b01 rising, 2'b10 both, 2'b11 none. A pin change is counted at the third clock edge after it.
- R5: With cfg_src_chain = 1, each clock cycle in which chain_evt is high is one event, whatever value cfg_edge holds, and pin_async is ignored.
- R6: With cfg_src_chain = 0, chain_evt has no effect on the count.
- R7: A run write of 0 stops counting: events leave the count unchanged and raise no underflow.
- R8: A count write while stopped, or after start but before the first event, loads both the counter and the reload value at the next edge.
- R9: A count write after the first event since start changes only the reload value. The counter keeps its value and takes the new value at its next reload.
- R10: A run write of 1 while stopped clears the first-event record, so count writes load the counter again until the next event.
- R11: With cfg_op_mode other than 2'b01, no event changes the count or raises an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op_mode | input | 2 | Operating mode; 2'b01 enables event counting |
| cfg_edge | input | 2 | Pin edge choice (00 fall, 01 rise, 10 both, 11 none) |
| cfg_src_chain | input | 1 | Event source: 0 pin, 1 preceding channel |
| run_we | input | 1 | Run bit write strobe |
| run_wdata | input | 1 | Run bit value: 1 start, 0 stop |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Count write value n |
| cnt_rdata | output | CNT_W | Live counter value |
| pin_async | input | 1 | Asynchronous external event pin |
| chain_evt | input | 1 | Underflow pulse of the preceding channel |
| uflow_pulse | output | 1 | One-cycle underflow pulse for chaining |
| irq_req | output | 1 | One-cycle interrupt request on underflow |

## Verification
Register writes and chained events show their effect on cnt_rdata one clock edge after they are driven. A pin change takes three edges: two synchroniser stages and the edge comparison. The underflow and interrupt pulses appear after the same edge as the reload and drop at the next edge. A reference model in the bench advances once per rising edge, keeping the same three-edge pin delay. It pushes its expected count, underflow and interrupt values into a queue, and a monitor pops and compares them 1 ns after that edge, so every result is checked in the cycle it is due.

// File: rtl/tmr_pkg.sv
// Shared types for the event down-counter channel.
// Assumes: the edge field encoding is fixed and must match the register map.
package tmr_pkg;
    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    localparam logic [1:0] OPM_EVENT = 2'b01;
endpackage

// File: rtl/evt_edge_sync.sv
// Brings an asynchronous pin into the clock domain through SYNC_STAGES
// flops, then compares it against one further registered copy to produce
// one-cycle rise and fall strobes.
// Assumes: SYNC_STAGES >= 2; the pin is low at reset release, otherwise a
// spurious rise strobe appears.
module evt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] sh;

    // Stage 0 captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= pin_async;
    end

    // Remaining stages form the synchroniser and the compare copy.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= sh[g-1];
        end
    end

    // Edge strobes from the last synchronised stage against its delayed copy.
    always_comb begin
        rise = sh[DEPTH-2] & ~sh[DEPTH-1];
        fall = ~sh[DEPTH-2] & sh[DEPTH-1];
    end
endmodule

// File: rtl/evt_src_mux.sv
// Picks the event strobe: a chained underflow pulse, or pin edges filtered
// by the edge selection field. The edge field has no effect in chained mode.
// Assumes: all inputs are single-cycle strobes in the clock domain.
module evt_src_mux
    import tmr_pkg::*;
(
    input  edge_sel_e edge_sel,
    input  logic      src_chain,
    input  logic      pin_rise,
    input  logic      pin_fall,
    input  logic      chain_evt,
    output logic      evt
);
    // Source and edge selection.
    always_comb begin
        if (src_chain) begin
            evt = chain_evt;
        end else begin
            unique case (edge_sel)
                EDGE_FALL: evt = pin_fall;
                EDGE_RISE: evt = pin_rise;
                EDGE_BOTH: evt = pin_rise | pin_fall;
                default:   evt = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_ctrl_regs.sv
// Holds the configuration fields and the run bit, and derives the counting
// enable and the start strobe (run bit written 1 while it is 0).
// Assumes: configuration and run writes are single-cycle strobes.
module tmr_ctrl_regs
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_op_mode,
    input  logic [1:0] cfg_edge,
    input  logic       cfg_src_chain,
    input  logic       run_we,
    input  logic       run_wdata,
    output edge_sel_e  edge_sel,
    output logic       src_chain,
    output logic       run,
    output logic       active,
    output logic       run_start
);
    logic [1:0] op_mode_q;

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_mode_q <= 2'b00;
            edge_sel  <= EDGE_FALL;
            src_chain <= 1'b0;
        end else if (cfg_we) begin
            op_mode_q <= cfg_op_mode;
            edge_sel  <= edge_sel_e'(cfg_edge);
            src_chain <= cfg_src_chain;
        end
    end

    // Run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      run <= 1'b0;
        else if (run_we) run <= run_wdata;
    end

    // Counting enable and start strobe.
    always_comb begin
        active    = run && (op_mode_q == OPM_EVENT);
        run_start = run_we && run_wdata && !run;
    end
endmodule

// File: rtl/cnt_core.sv
// Down-counter with reload register, first-event record and underflow
// pulses. A write loads the counter too while stopped or before the first
// event since start; afterwards only the reload register changes.
// Assumes: evt is a one-cycle strobe. A write that coincides with an
// underflow reload hands its value straight to the counter.
module cnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             run,
    input  logic             run_start,
    input  logic             evt,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] reload,
    output logic             seen,
    output logic             uflow,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic ld_both;
    logic evt_cnt;
    logic at_zero;

    // Decode of the write and count conditions.
    always_comb begin
        ld_both = wr_en && (!run || !seen);
        evt_cnt = evt && active;
        at_zero = (cnt == ZERO);
    end

    // Reload register: every write lands here.
    always_ff @(posedge clk) begin
        if (!rst_n)     reload <= ZERO;
        else if (wr_en) reload <= wr_data;
    end

    // Counter: a direct load wins, else decrement or reload on an event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= ZERO;
        end else if (ld_both) begin
            cnt <= wr_data;
        end else if (evt_cnt) begin
            if (at_zero) cnt <= wr_en ? wr_data : reload;
            else         cnt <= cnt - ONE;
        end
    end

    // First-event record: cleared on start, set by the first counted event.
    always_ff @(posedge clk) begin
        if (!rst_n)         seen <= 1'b0;
        else if (run_start) seen <= 1'b0;
        else if (evt_cnt)   seen <= 1'b1;
    end

    // Underflow and interrupt pulses, registered alongside the reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uflow <= 1'b0;
            irq   <= 1'b0;
        end else begin
            uflow <= evt_cnt && at_zero && !ld_both;
            irq   <= evt_cnt && at_zero && !ld_both;
        end
    end
endmodule

// File: rtl/evt_down_timer.sv
// One channel of a reloadable event down-counter. It counts pin edges or
// the preceding channel's underflow pulses, and reloads on underflow.
// Assumes: chain_evt is already in the clock domain; pin_async is not.
module evt_down_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_op_mode,
    input  logic [1:0]       cfg_edge,
    input  logic             cfg_src_chain,
    input  logic             run_we,
    input  logic             run_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             pin_async,
    input  logic             chain_evt,
    output logic             uflow_pulse,
    output logic             irq_req
);
    edge_sel_e        edge_sel;
    logic             src_chain;
    logic             run_q;
    logic             active;
    logic             run_start;
    logic             pin_rise;
    logic             pin_fall;
    logic             evt_sel;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             seen_q;

    tmr_ctrl_regs u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_op_mode   (cfg_op_mode),
        .cfg_edge      (cfg_edge),
        .cfg_src_chain (cfg_src_chain),
        .run_we        (run_we),
        .run_wdata     (run_wdata),
        .edge_sel      (edge_sel),
        .src_chain     (src_chain),
        .run           (run_q),
        .active        (active),
        .run_start     (run_start)
    );

    evt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_async),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    evt_src_mux u_mux (
        .edge_sel  (edge_sel),
        .src_chain (src_chain),
        .pin_rise  (pin_rise),
        .pin_fall  (pin_fall),
        .chain_evt (chain_evt),
        .evt       (evt_sel)
    );

    cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .run       (run_q),
        .run_start (run_start),
        .evt       (evt_sel),
        .wr_en     (cnt_we),
        .wr_data   (cnt_wdata),
        .cnt       (cnt_q),
        .reload    (reload_q),
        .seen      (seen_q),
        .uflow     (uflow_pulse),
        .irq       (irq_req)
    );

    // Read path: the live counter.
    always_comb cnt_rdata = cnt_q;
endmodule

// File: rtl/evt_down_timer_chk.sv
// Property checker for the event down-counter, attached by bind.
module evt_down_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt,
    input logic             active,
    input logic             run,
    input logic             seen,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             uflow,
    input logic             irq
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && reload == '0 && !run && !uflow && !irq));

    p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && active && cnt != '0 && !cnt_we) |=> (cnt == $past(cnt) - 1'b1));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && active && cnt == '0 && !cnt_we) |=> (uflow && irq && cnt == $past(reload)));

    p_uflow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |-> ($past(cnt) == '0 && $past(evt) && $past(active)));

    p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we) |=> ($stable(cnt) && !uflow));

    p_reload_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && seen && cnt_we && !evt) |=> $stable(cnt));

    p_idle_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !cnt_we) |=> $stable(cnt));
endmodule

bind evt_down_timer evt_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_sel),
    .active (active),
    .run    (run_q),
    .seen   (seen_q),
    .cnt_we (cnt_we),
    .cnt    (cnt_q),
    .reload (reload_q),
    .uflow  (uflow_pulse),
    .irq    (irq_req)
);

// File: tb/tb_evt_down_timer.sv
module tb_evt_down_timer;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_op_mode = 2'b00;
    logic [1:0] cfg_edge = 2'b00;
    logic cfg_src_chain = 1'b0;
    logic run_we = 1'b0;
    logic run_wdata = 1'b0;
    logic cnt_we = 1'b0;
    logic [W-1:0] cnt_wdata = '0;
    logic [W-1:0] cnt_rdata;
    logic pin_async = 1'b0;
    logic chain_evt = 1'b0;
    logic uflow_pulse;
    logic irq_req;

    always #2.5 clk = ~clk;

    evt_down_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_op_mode(cfg_op_mode),
        .cfg_edge(cfg_edge), .cfg_src_chain(cfg_src_chain), .run_we(run_we),
        .run_wdata(run_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .pin_async(pin_async), .chain_evt(chain_evt),
        .uflow_pulse(uflow_pulse), .irq_req(irq_req)
    );

    typedef struct {
        logic [W-1:0] cnt;
        logic         uf;
        logic         irq;
        string        req;
    } exp_t;

    exp_t  sb[$];
    string tag = "R1";
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Reference model state, built from the requirements.
    logic [W-1:0] m_cnt, m_rel;
    logic [1:0]   m_mode, m_edge;
    logic         m_src, m_run, m_seen, m_uf;
    logic         p0, p1, p2;

    // Model: one step per rising edge; pushes what the outputs must show after it.
    always @(posedge clk) begin
        exp_t e;
        logic rise, fall, ev, ld;
        if (!rst_n) begin
            m_cnt = '0; m_rel = '0; m_mode = 2'b00; m_edge = 2'b00;
            m_src = 1'b0; m_run = 1'b0; m_seen = 1'b0; m_uf = 1'b0;
            p0 = 1'b0; p1 = 1'b0; p2 = 1'b0;
        end else begin
            rise = p1 & ~p2;
            fall = ~p1 & p2;
            if (m_src) ev = chain_evt;
            else case (m_edge)
                2'b00: ev = fall;
                2'b01: ev = rise;
                2'b10: ev = rise | fall;
                default: ev = 1'b0;
            endcase
            ev = ev && m_run && (m_mode == 2'b01);
            ld = cnt_we && (!m_run || !m_seen);
            m_uf = 1'b0;
            if (ld) m_cnt = cnt_wdata;
            else if (ev) begin
                if (m_cnt == '0) begin
                    m_cnt = cnt_we ? cnt_wdata : m_rel;
                    m_uf = 1'b1;
                end else m_cnt = m_cnt - 1'b1;
            end
            if (cnt_we) m_rel = cnt_wdata;
            if (run_we && run_wdata && !m_run) m_seen = 1'b0;
            else if (ev) m_seen = 1'b1;
            if (run_we) m_run = run_wdata;
            if (cfg_we) begin
                m_mode = cfg_op_mode; m_edge = cfg_edge; m_src = cfg_src_chain;
            end
            p2 = p1; p1 = p0; p0 = pin_async;
        end
        e.cnt = m_cnt; e.uf = m_uf; e.irq = m_uf; e.req = tag;
        sb.push_back(e);
    end

    // Monitor: compare each due item 1 ns after its edge.
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (cnt_rdata !== e.cnt || uflow_pulse !== e.uf || irq_req !== e.irq) begin
                n_bad++;
                $display("FAIL %s: cnt=%0d uf=%0b irq=%0b expected cnt=%0d uf=%0b irq=%0b",
                         e.req, cnt_rdata, uflow_pulse, irq_req, e.cnt, e.uf, e.irq);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] opm, input logic [1:0] edg, input logic src);
        @(negedge clk);
        cfg_we = 1'b1; cfg_op_mode = opm; cfg_edge = edg; cfg_src_chain = src;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_run(input logic v);
        @(negedge clk);
        run_we = 1'b1; run_wdata = v;
        @(negedge clk);
        run_we = 1'b0;
    endtask

    task automatic wr(input logic [W-1:0] v);
        @(negedge clk);
        cnt_we = 1'b1; cnt_wdata = v;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic chain(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chain_evt = 1'b1;
            @(negedge clk);
            chain_evt = 1'b0;
        end
    endtask

    task automatic pin_toggles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pin_async = ~pin_async;
            idle(4);
        end
    endtask

    initial begin
        tag = "R1";
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        tag = "R8";                       // loads counter while stopped and before first event
        cfg(2'b01, 2'b00, 1'b1);
        wr(16'd3);
        set_run(1'b1);
        wr(16'd5);
        idle(1);
        tag = "R2";                       // decrement per chained event
        chain(2);
        tag = "R9";                       // write after first event: reload only
        wr(16'd9);
        idle(2);
        chain(3);
        tag = "R3";                       // underflow reloads 9 and pulses
        chain(2);
        set_run(1'b0);
        wr(16'd0);
        set_run(1'b1);
        chain(3);                         // n = 0: every event underflows
        tag = "R5";                       // chained source ignores edge field and pin
        wr(16'd4);
        cfg(2'b01, 2'b11, 1'b1);
        chain(2);
        pin_toggles(2);
        tag = "R6";                       // pin source ignores chain input
        cfg(2'b01, 2'b01, 1'b0);
        chain(3);
        tag = "R4";                       // rising only, then falling, both, none
        pin_toggles(4);
        cfg(2'b01, 2'b00, 1'b0);
        pin_toggles(4);
        cfg(2'b01, 2'b10, 1'b0);
        pin_toggles(4);
        cfg(2'b01, 2'b11, 1'b0);
        pin_toggles(2);
        tag = "R7";                       // stopped: no counting
        cfg(2'b01, 2'b10, 1'b0);
        set_run(1'b0);
        pin_toggles(2);
        cfg(2'b01, 2'b10, 1'b1);
        chain(2);
        tag = "R10";                      // restart clears first-event record
        set_run(1'b1);
        chain(1);
        wr(16'd20);
        set_run(1'b0);
        set_run(1'b1);
        wr(16'd7);
        idle(1);
        chain(2);
        tag = "R11";                      // non-event mode: no counting
        cfg(2'b00, 2'b10, 1'b1);
        chain(2);
        cfg(2'b11, 2'b10, 1'b0);
        pin_toggles(2);
        idle(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule